// File: doc/BRIEF.md
# Instruction Address Match Trap Unit

This unit sits next to a processor's instruction sequencer and acts as a hardware breakpoint or ROM-patch trigger. Software loads two watch addresses, slot 0 and slot 1, through a small register write port, and sets a separate enable bit for each. Each time the sequencer flags the first byte of the next instruction, the unit compares that address against the enabled slots. On a qualified hit it raises a one-cycle trap request. This happens before the instruction retires, so the CPU can divert to a single shared handler vector.

With the request the unit supplies the value the CPU pushes onto the stack. That value is the matched address advanced by one or two, as chosen by a decoder class hint. It also supplies a status bit naming the slot that hit, because both slots share one vector. Several things block a hit: no priority level or global interrupt flag takes part in the decision, but the first instruction of any interrupt handler, instructions fetched from a narrow 8-bit external area, and any hit while an earlier trap awaits acknowledgement are all excluded.

Top module: `addr_match_trap`

## Requirements
- R1: After a synchronous active-low reset both watch addresses are zero and both enables are cleared. `trap_req`, `stack_addr` and `match_id` read 0, so an instruction at address 0 raises no trap.
- R2: A write with `reg_sel`=0 or 1 loads `reg_wdata` into watch slot 0 or 1. `reg_sel`=2 loads the enables from `reg_wdata[0]` (slot 0) and `reg_wdata[1]` (slot 1). `reg_sel`=3 changes nothing.
- R3: When `insn_start` is high and an enabled slot equals `insn_addr`, `trap_req` is high for exactly one cycle, in the cycle after the strobe, unless R6, R7 or R10 block it. No priority level or global interrupt enable takes part.
- R4: A slot whose enable bit is 0 never causes a trap.
- R5: An address presented while `insn_start` is low never causes a trap. This covers operand bytes, mid-instruction addresses and table-data fetches.
- R6: An instruction flagged by `isr_first` (first of an interrupt handler) never causes a trap.
- R7: An instruction flagged by `ext_narrow` (external area on an 8-bit bus) never causes a trap.
- R8: Along with `trap_req`, `stack_addr` equals the matched address plus 2 when `op_long`=1 and plus 1 when `op_long`=0, modulo 2^AW. It holds that value until the next trap.
- R9: Along with `trap_req`, `match_id` gives the slot that hit. When both slots hit, only one request is raised and `match_id`=0.
- R10: After a trap, further hits are dropped from the cycle of the request through the cycle in which `trap_ack` is high. Hits are accepted again in the cycle after that.
- R11: `trap_vector` carries the single handler vector parameter, whichever slot hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 slot 0, 1 slot 1, 2 enables, 3 unused |
| reg_wdata | input | AW | Register write data |
| insn_addr | input | AW | Address of the instruction about to execute |
| insn_start | input | 1 | High when insn_addr is the first byte of an instruction |
| op_long | input | 1 | Decoder class hint: 1 = offset 2, 0 = offset 1 |
| isr_first | input | 1 | Instruction is the first of an interrupt handler |
| ext_narrow | input | 1 | Address lies in an 8-bit-wide external area |
| trap_ack | input | 1 | CPU acknowledges the outstanding trap |
| trap_req | output | 1 | One-cycle trap request |
| trap_vector | output | AW | Shared handler vector |
| stack_addr | output | AW | Value for the CPU to push |
| match_id | output | 1 | Slot that caused the last trap |

## Verification
A corrupted watch register or enable shows at the ports one cycle after the first strobed instruction at the affected address: a trap is either missing or spurious. A stuck outstanding-trap flag shows as hits that are dropped after an acknowledge, or as a second pulse before one. The bench sweeps every address of an 8-bit configuration under every mix of strobe, handler-entry and narrow-bus flags and several enable patterns, and compares each cycle against an arithmetic model. Offset errors in `stack_addr` and priority errors in `match_id` therefore appear on the same cycle as the request they belong to.

// File: rtl/amt_pkg.sv
// Shared constants for the address match trap unit.
// Assumes exactly two watch slots; the register select encoding is fixed.
package amt_pkg;
    localparam int NSLOT = 2;
    localparam int IDW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    typedef enum logic [1:0] {
        SEL_SLOT0 = 2'd0,
        SEL_SLOT1 = 2'd1,
        SEL_EN    = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/amt_regfile.sv
// Watch address and enable storage with a plain write port.
// Assumes one write per cycle; select 3 is a no-op.
module amt_regfile
    import amt_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 sel,
    input  logic [AW-1:0]              wdata,
    output logic [NSLOT-1:0][AW-1:0]   slot_addr,
    output logic [NSLOT-1:0]           slot_en
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        // Load watch address i when its select value is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_addr[i] <= '0;
            else if (we && sel == 2'(i))
                slot_addr[i] <= wdata;
        end
    end

    // Load all enable bits together from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_en <= '0;
        else if (we && reg_sel_e'(sel) == SEL_EN)
            slot_en <= wdata[NSLOT-1:0];
    end
endmodule

// File: rtl/amt_hit_detect.sv
// Per-slot equality compare of the current instruction address.
// Assumes qualification by strobe and flags is done downstream.
module amt_hit_detect
    import amt_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [AW-1:0]              addr,
    input  logic [NSLOT-1:0][AW-1:0]   slot_addr,
    input  logic [NSLOT-1:0]           slot_en,
    output logic [NSLOT-1:0]           hit
);
    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        // An enabled slot hits on exact address equality.
        assign hit[i] = slot_en[i] && (addr == slot_addr[i]);
    end
endmodule

// File: rtl/amt_trap_ctl.sv
// Qualifies hits, raises the request, computes the stacked value and
// tracks the outstanding trap until acknowledged.
// Assumes the CPU holds the trapped instruction until it takes the request.
module amt_trap_ctl
    import amt_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSLOT-1:0]  hit,
    input  logic [AW-1:0]     addr,
    input  logic              start,
    input  logic              long_op,
    input  logic              isr_first,
    input  logic              narrow,
    input  logic              ack,
    output logic              req,
    output logic [AW-1:0]     push_val,
    output logic [IDW-1:0]    which,
    output logic              pend
);
    logic [IDW-1:0] pick;
    logic           fire;
    logic [AW-1:0]  step_sz;

    // Lowest-numbered hitting slot wins.
    always_comb begin
        pick = '0;
        for (int i = NSLOT - 1; i >= 0; i--)
            if (hit[i]) pick = IDW'(i);
    end

    // A trap is taken only on a strobed, unblocked hit.
    assign fire    = start && (|hit) && !isr_first && !narrow && !pend;
    assign step_sz = long_op ? AW'(2) : AW'(1);

    // Register request, stacked value, slot id and outstanding flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= 1'b0;
            push_val <= '0;
            which    <= '0;
            pend     <= 1'b0;
        end else begin
            req <= fire;
            if (fire) begin
                push_val <= addr + step_sz;
                which    <= pick;
                pend     <= 1'b1;
            end else if (ack) begin
                pend     <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/addr_match_trap.sv
// Top of the instruction address match trap unit: two watch slots,
// one shared vector, one outstanding trap at a time.
// Assumes insn_start, op_long, isr_first and ext_narrow are valid together.
module addr_match_trap
    import amt_pkg::*;
#(
    parameter int          AW     = 20,
    parameter logic [AW-1:0] VECTOR = 20'hFFFD8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic [AW-1:0] insn_addr,
    input  logic          insn_start,
    input  logic          op_long,
    input  logic          isr_first,
    input  logic          ext_narrow,
    input  logic          trap_ack,
    output logic          trap_req,
    output logic [AW-1:0] trap_vector,
    output logic [AW-1:0] stack_addr,
    output logic          match_id
);
    logic [NSLOT-1:0][AW-1:0] slot_addr;
    logic [NSLOT-1:0]         slot_en;
    logic [NSLOT-1:0]         hit;
    logic [IDW-1:0]           which;
    logic                     pend;

    amt_regfile #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .slot_addr(slot_addr), .slot_en(slot_en)
    );

    amt_hit_detect #(.AW(AW)) u_hit (
        .addr(insn_addr), .slot_addr(slot_addr), .slot_en(slot_en), .hit(hit)
    );

    amt_trap_ctl #(.AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .hit(hit), .addr(insn_addr),
        .start(insn_start), .long_op(op_long), .isr_first(isr_first),
        .narrow(ext_narrow), .ack(trap_ack), .req(trap_req),
        .push_val(stack_addr), .which(which), .pend(pend)
    );

    // Both slots share one handler vector.
    assign trap_vector = VECTOR;
    assign match_id    = which[0];
endmodule

// File: rtl/addr_match_trap_chk.sv
// Temporal checks on the trap unit's ports and held state.
module addr_match_trap_chk
    import amt_pkg::*;
#(
    parameter int AW = 20
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [AW-1:0]            insn_addr,
    input logic                     insn_start,
    input logic                     op_long,
    input logic                     isr_first,
    input logic                     ext_narrow,
    input logic                     trap_ack,
    input logic                     trap_req,
    input logic [AW-1:0]            stack_addr,
    input logic [NSLOT-1:0][AW-1:0] slot_addr,
    input logic [NSLOT-1:0]         slot_en,
    input logic                     pend
);
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    p_enabled_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past((slot_en[0] && insn_addr == slot_addr[0]) ||
                           (slot_en[1] && insn_addr == slot_addr[1])));

    p_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(insn_start));

    p_handler_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !$past(isr_first));

    p_narrow_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !$past(ext_narrow));

    p_stack_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> stack_addr == $past(insn_addr) + ($past(op_long) ? AW'(2) : AW'(1)));

    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !trap_ack) |=> !trap_req);
endmodule

bind addr_match_trap addr_match_trap_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_addr(insn_addr), .insn_start(insn_start),
    .op_long(op_long), .isr_first(isr_first), .ext_narrow(ext_narrow),
    .trap_ack(trap_ack), .trap_req(trap_req), .stack_addr(stack_addr),
    .slot_addr(slot_addr), .slot_en(slot_en), .pend(pend)
);

// File: tb/sim_addr_match_trap.sv
module sim_addr_match_trap;
    localparam int AW = 8;
    localparam logic [7:0] VEC = 8'hD8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0, insn_addr = '0;
    logic insn_start = 1'b0, op_long = 1'b0, isr_first = 1'b0;
    logic ext_narrow = 1'b0, trap_ack = 1'b0;
    logic trap_req, match_id;
    logic [7:0] trap_vector, stack_addr;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_addr [2];
    bit   m_en [2];
    bit   m_pend = 1'b0;
    logic [7:0] m_stack = '0;
    bit   m_id = 1'b0;

    always #5 clk = ~clk;

    addr_match_trap #(.AW(AW), .VECTOR(VEC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .insn_addr(insn_addr), .insn_start(insn_start),
        .op_long(op_long), .isr_first(isr_first), .ext_narrow(ext_narrow),
        .trap_ack(trap_ack), .trap_req(trap_req), .trap_vector(trap_vector),
        .stack_addr(stack_addr), .match_id(match_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (s < 2) m_addr[s] = d;
        else if (s == 2) begin m_en[0] = d[0]; m_en[1] = d[1]; end
    endtask

    // Drive one instruction cycle and compare against the model.
    task automatic step(input logic [7:0] a, input bit s, input bit l,
                        input bit isr, input bit nar, input bit ack);
        bit h0, h1, raw, fire;
        string tag;
        h0   = m_en[0] && a == m_addr[0];
        h1   = m_en[1] && a == m_addr[1];
        raw  = (a == m_addr[0]) || (a == m_addr[1]);
        fire = s && (h0 || h1) && !isr && !nar && !m_pend;
        if (fire)                     tag = "R3";
        else if (raw && !(h0 || h1))  tag = "R4";
        else if (!s && (h0 || h1))    tag = "R5";
        else if (isr && (h0 || h1))   tag = "R6";
        else if (nar && (h0 || h1))   tag = "R7";
        else if (m_pend && (h0 || h1)) tag = "R10";
        else                          tag = "R3";
        @(negedge clk);
        insn_addr = a; insn_start = s; op_long = l;
        isr_first = isr; ext_narrow = nar; trap_ack = ack;
        @(posedge clk);
        #1;
        if (fire) begin
            m_stack = a + (l ? 8'd2 : 8'd1);
            m_id    = !h0;
            m_pend  = 1'b1;
        end else if (ack) m_pend = 1'b0;
        chk(trap_req == fire, tag, trap_req, fire);
        chk(stack_addr == m_stack, "R8", stack_addr, m_stack);
        if (fire) chk(match_id == m_id, "R9", match_id, m_id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_addr[0] = 0; m_addr[1] = 0; m_en[0] = 0; m_en[1] = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(trap_req == 1'b0, "R1", trap_req, 0);
        chk(stack_addr == 8'h00, "R1", stack_addr, 0);
        chk(match_id == 1'b0, "R1", match_id, 0);
        step(8'h00, 1, 0, 0, 0, 0);
        chk(trap_req == 1'b0, "R1", trap_req, 0);
        chk(trap_vector == VEC, "R11", trap_vector, VEC);

        // R2: register writes; select 3 must not disturb anything
        wr(2'd0, 8'h35); wr(2'd1, 8'h9A); wr(2'd2, 8'h03);
        wr(2'd3, 8'hFF);
        step(8'h35, 1, 0, 0, 0, 0);
        chk(trap_req && stack_addr == 8'h36, "R2", stack_addr, 8'h36);
        step(8'h00, 0, 0, 0, 0, 1);
        step(8'h9A, 1, 1, 0, 0, 0);
        chk(trap_req && match_id == 1'b1 && stack_addr == 8'h9C, "R2", stack_addr, 8'h9C);
        chk(trap_vector == VEC, "R11", trap_vector, VEC);

        // R10: held request, hit during ack dropped, accepted after
        step(8'h35, 1, 0, 0, 0, 0);
        step(8'h35, 1, 0, 0, 0, 1);
        step(8'h35, 1, 0, 0, 0, 0);
        chk(trap_req == 1'b1, "R10", trap_req, 1);
        step(8'h00, 0, 0, 0, 0, 1);

        // R9: both slots on one address, then slot 0 disabled
        wr(2'd1, 8'h35);
        step(8'h35, 1, 1, 0, 0, 0);
        chk(match_id == 1'b0, "R9", match_id, 0);
        step(8'h00, 0, 0, 0, 0, 1);
        wr(2'd2, 8'h02);
        step(8'h35, 1, 1, 0, 0, 0);
        chk(match_id == 1'b1, "R9", match_id, 1);
        step(8'h00, 0, 0, 0, 0, 1);

        // R8: wrap of the stacked value
        wr(2'd0, 8'hFF); wr(2'd2, 8'h01);
        step(8'hFF, 1, 1, 0, 0, 0);
        chk(stack_addr == 8'h01, "R8", stack_addr, 8'h01);
        step(8'h00, 0, 0, 0, 0, 1);

        // Sweep: all addresses x flag mixes x enable patterns (R3..R10)
        wr(2'd0, 8'h35); wr(2'd1, 8'h9A);
        for (int p = 0; p < 3; p++) begin
            wr(2'd2, (p == 0) ? 8'h03 : (p == 1) ? 8'h01 : 8'h02);
            for (int a = 0; a < 256; a++) begin
                for (int v = 0; v < 8; v++) begin
                    step(8'(a), v[0] | v[1], v[2] ^ a[0], v == 2 || v == 7,
                         v == 6 || v == 3, m_pend && (a % 3 != 0));
                end
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule